// File: doc/BRIEF.md
# Software-Refilled Translation Buffer

This block is the only address translation hardware on its path. It is a fully associative cache of page mappings, and there is no page table walker behind it. A requester presents a 20-bit virtual page number, which is the upper part of a 32-bit address with a 4 KB page offset. One cycle later the block reports whether the page is mapped and, on a hit, returns the 20-bit physical page number.

When the lookup misses, the block never reads memory. Instead it raises a one-cycle trap request and records the faulting page number so that the handler can read it. The handler resolves the mapping itself and installs it through a refill write port. The handler can name the slot to fill, or let a round-robin victim pointer choose one. A refill whose page number is already present replaces that existing slot, so no page ever occupies two slots. A flush input invalidates the whole buffer in a single cycle, for example on an address-space switch.

Top module: `sw_tlb`

## Requirements
- R1: After reset, every slot is invalid, the victim pointer is at slot 0, and `rs_valid`, `rs_hit`, `rs_ppn`, `trap_req`, `fault_pend` and `fault_vpn` are all 0.
- R2: A request with `lk_req`=1 produces `rs_valid`=1 exactly one cycle later. On a hit, `rs_hit`=1 and `rs_ppn` carries the physical page number stored for that virtual page. A cycle without a request gives `rs_valid`=0.
- R3: On a miss, one cycle after the request, `trap_req`=1 for one cycle, with `rs_hit`=0 and `rs_ppn`=0. `trap_req` is never 1 without a miss.
- R4: A miss that occurs while no fault is pending captures the requested page into `fault_vpn` and sets `fault_pend`. Later misses leave `fault_vpn` unchanged until a refill write is performed, and that write clears `fault_pend`. A miss in the same cycle as a performed write captures a new fault.
- R5: A performed write (`wr_en`=1, `flush`=0) stores `wr_vpn` and `wr_ppn` as a valid slot, so that later lookups of `wr_vpn` hit. With `wr_use_idx`=1 the slot is `wr_idx`.
- R6: With `wr_use_idx`=0, a write of a page not already present goes to the victim pointer. The pointer then advances by one, wrapping from slot 63 back to slot 0, so the 65th such write after reset evicts the first.
- R7: A write whose `wr_vpn` matches a valid slot overwrites that slot, whatever `wr_use_idx` and `wr_idx` say, and leaves the victim pointer where it is.
- R8: `flush`=1 makes every slot invalid on the next cycle. A write presented in the same cycle as a flush is dropped: it neither installs, advances the pointer nor clears a pending fault.
- R9: A lookup presented in the same cycle as a write or flush is answered from the contents held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| rs_valid | output | 1 | Lookup result present (one cycle after request) |
| rs_hit | output | 1 | Result is a hit |
| rs_ppn | output | 20 | Physical page number on hit, else 0 |
| trap_req | output | 1 | Miss trap to software, one-cycle pulse |
| fault_pend | output | 1 | A captured fault awaits a refill |
| fault_vpn | output | 20 | Captured faulting virtual page number |
| wr_en | input | 1 | Refill write strobe |
| wr_use_idx | input | 1 | 1: use `wr_idx`; 0: use victim pointer |
| wr_idx | input | 6 | Explicit slot for the write |
| wr_vpn | input | 20 | Virtual page number being installed |
| wr_ppn | input | 20 | Physical page number being installed |
| flush | input | 1 | Invalidate all slots |

## Verification
The assertions check on every cycle the properties that hold locally. No page ever matches two slots. Results follow requests by one cycle, and traps coincide only with misses. The pointer steps only on a fresh round-robin install. A pending fault address stays stable until a refill, and a flush leaves no valid slot. Other behaviours only the bench scenarios can show, because they need a model of the contents. These are the translation value returned, eviction by the wrapped pointer after 64 installs, a duplicate refill replacing the old slot, a write being dropped under a flush, and a same-cycle lookup being answered from the old contents.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;
    parameter int VPN_W = 20;
    parameter int PPN_W = 20;
    parameter int N_ENT = 64;
    localparam int IDX_W = $clog2(N_ENT);

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_ent_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [PPN_W-1:0] ppn;
    } match_t;

    function automatic logic [IDX_W-1:0] next_slot(input logic [IDX_W-1:0] cur);
        if (cur == IDX_W'(N_ENT - 1))
            return '0;
        return cur + IDX_W'(1);
    endfunction
endpackage

// File: rtl/sw_tlb_match.sv
module sw_tlb_match
    import sw_tlb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  tlb_ent_t              ents [N_ENT],
    input  logic [VPN_W-1:0]      key,
    output logic [N_ENT-1:0]      hit_vec,
    output match_t                res
);
    // one comparator per slot
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign hit_vec[g] = ents[g].valid && (ents[g].vpn == key);
    end

    // OR-encode; correct because at most one slot matches
    always_comb begin
        res.hit = |hit_vec;
        res.idx = '0;
        res.ppn = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit_vec[i]) begin
                res.idx = res.idx | IDX_W'(i);
                res.ppn = res.ppn | ents[i].ppn;
            end
        end
    end

    // R7: no page may live in two slots
    p_unique_r7: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_vec));
endmodule

// File: rtl/sw_tlb_store.sv
module sw_tlb_store
    import sw_tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [VPN_W-1:0]  wvpn,
    input  logic [PPN_W-1:0]  wppn,
    output tlb_ent_t          ents [N_ENT]
);
    logic [N_ENT-1:0] vmask;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g] <= '0;
            end else if (flush) begin
                ents[g].valid <= 1'b0;
            end else if (we && widx == IDX_W'(g)) begin
                ents[g].valid <= 1'b1;
                ents[g].vpn   <= wvpn;
                ents[g].ppn   <= wppn;
            end
        end
        assign vmask[g] = ents[g].valid;
    end

    // R8: a flush leaves nothing valid
    p_flush_clear_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vmask == '0));
    // R5: a write lands as a valid slot
    p_write_valid_r5: assert property (@(posedge clk) disable iff (rst)
        (we && !flush) |=> vmask[$past(widx)]);
endmodule

// File: rtl/sw_tlb_victim.sv
module sw_tlb_victim
    import sw_tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [IDX_W-1:0]  ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= next_slot(ptr);
    end

    // R6: step by one with wrap on each fresh round-robin install
    p_rr_step_r6: assert property (@(posedge clk) disable iff (rst)
        adv |=> ptr == next_slot($past(ptr)));
    // R7: otherwise the pointer holds
    p_rr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ptr));
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
    import sw_tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic [PPN_W-1:0]  rs_ppn,
    output logic              trap_req,
    output logic              fault_pend,
    output logic [VPN_W-1:0]  fault_vpn,
    input  logic              wr_en,
    input  logic              wr_use_idx,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic              flush
);
    tlb_ent_t         ents [N_ENT];
    logic [N_ENT-1:0] lk_vec;
    logic [N_ENT-1:0] wr_vec;
    match_t           lk_m;
    match_t           wr_m;
    logic [IDX_W-1:0] ptr;
    logic [IDX_W-1:0] slot;
    logic             wr_go;
    logic             adv;
    logic             miss;

    sw_tlb_match u_lk_match (
        .clk(clk), .rst(rst), .ents(ents), .key(lk_vpn),
        .hit_vec(lk_vec), .res(lk_m)
    );

    sw_tlb_match u_wr_match (
        .clk(clk), .rst(rst), .ents(ents), .key(wr_vpn),
        .hit_vec(wr_vec), .res(wr_m)
    );

    // refill steering: an existing match wins, then an explicit index, then the victim pointer
    always_comb begin
        wr_go = wr_en && !flush;
        adv   = wr_go && !wr_m.hit && !wr_use_idx;
        if (wr_m.hit)
            slot = wr_m.idx;
        else if (wr_use_idx)
            slot = wr_idx;
        else
            slot = ptr;
    end

    sw_tlb_victim u_victim (
        .clk(clk), .rst(rst), .adv(adv), .ptr(ptr)
    );

    sw_tlb_store u_store (
        .clk(clk), .rst(rst), .flush(flush), .we(wr_go), .widx(slot),
        .wvpn(wr_vpn), .wppn(wr_ppn), .ents(ents)
    );

    assign miss = lk_req && !lk_m.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_ppn   <= '0;
            trap_req <= 1'b0;
        end else begin
            rs_valid <= lk_req;
            rs_hit   <= lk_req && lk_m.hit;
            rs_ppn   <= (lk_req && lk_m.hit) ? lk_m.ppn : '0;
            trap_req <= miss;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_pend <= 1'b0;
            fault_vpn  <= '0;
        end else if (miss && (!fault_pend || wr_go)) begin
            fault_pend <= 1'b1;
            fault_vpn  <= lk_vpn;
        end else if (wr_go) begin
            fault_pend <= 1'b0;
        end
    end

    // R2: a result follows every request by one cycle
    p_result_lat_r2: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rs_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rs_valid);
    // R3: a trap only accompanies a miss result
    p_trap_is_miss_r3: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (rs_valid && !rs_hit && rs_ppn == '0));
    // R4: a pending fault address is held until a refill
    p_fault_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (fault_pend && !wr_go) |=> (fault_pend && $stable(fault_vpn)));
endmodule

// File: tb/sw_tlb_tb.sv
`timescale 1ns/1ps
module sw_tlb_tb;
    localparam int NE = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_req;
    logic [19:0] lk_vpn;
    logic        rs_valid, rs_hit, trap_req, fault_pend;
    logic [19:0] rs_ppn, fault_vpn;
    logic        wr_en, wr_use_idx, flush;
    logic [5:0]  wr_idx;
    logic [19:0] wr_vpn, wr_ppn;

    always #5 clk = ~clk;

    sw_tlb u_dut (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_ppn(rs_ppn),
        .trap_req(trap_req), .fault_pend(fault_pend), .fault_vpn(fault_vpn),
        .wr_en(wr_en), .wr_use_idx(wr_use_idx), .wr_idx(wr_idx),
        .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .flush(flush)
    );

    // reference model
    logic        m_val [NE];
    logic [19:0] m_vpn [NE];
    logic [19:0] m_ppn [NE];
    int          m_ptr;
    logic        m_pend;
    logic [19:0] m_fvpn;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic int find(input logic [19:0] v);
        for (int i = 0; i < NE; i++)
            if (m_val[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NE; i++) begin
            m_val[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0;
        end
        m_ptr = 0; m_pend = 1'b0; m_fvpn = '0;
    endtask

    // one cycle: drive at negedge, model the edge, compare after it
    task automatic cyc(input string tag, input logic lk, input logic [19:0] lv,
                       input logic we, input logic ui, input logic [5:0] wi,
                       input logic [19:0] wv, input logic [19:0] wp, input logic fl);
        int  h, m, s;
        logic e_hit, e_miss, wgo;
        logic [19:0] e_ppn;
        @(negedge clk);
        lk_req = lk; lk_vpn = lv; wr_en = we; wr_use_idx = ui; wr_idx = wi;
        wr_vpn = wv; wr_ppn = wp; flush = fl;
        h      = find(lv);
        e_hit  = lk && (h >= 0);
        e_ppn  = e_hit ? m_ppn[h] : 20'h0;
        e_miss = lk && (h < 0);
        wgo    = we && !fl;
        if (fl) begin
            for (int i = 0; i < NE; i++) m_val[i] = 1'b0;
        end else if (we) begin
            m = find(wv);
            if (m >= 0) s = m;
            else if (ui) s = int'(wi);
            else begin s = m_ptr; m_ptr = (m_ptr + 1) % NE; end
            m_val[s] = 1'b1; m_vpn[s] = wv; m_ppn[s] = wp;
        end
        if (e_miss && (!m_pend || wgo)) begin
            m_pend = 1'b1; m_fvpn = lv;
        end else if (wgo) begin
            m_pend = 1'b0;
        end
        @(posedge clk);
        #2;
        check(tag, "rs_valid", 32'(rs_valid), 32'(lk));
        check(tag, "rs_hit", 32'(rs_hit), 32'(e_hit));
        check(tag, "rs_ppn", 32'(rs_ppn), 32'(e_ppn));
        check(tag, "trap_req", 32'(trap_req), 32'(e_miss));
        check(tag, "fault_pend", 32'(fault_pend), 32'(m_pend));
        check(tag, "fault_vpn", 32'(fault_vpn), 32'(m_fvpn));
    endtask

    task automatic look(input string tag, input logic [19:0] v);
        cyc(tag, 1'b1, v, 1'b0, 1'b0, 6'd0, 20'h0, 20'h0, 1'b0);
    endtask

    task automatic put(input string tag, input logic ui, input logic [5:0] wi,
                       input logic [19:0] v, input logic [19:0] p);
        cyc(tag, 1'b0, 20'h0, 1'b1, ui, wi, v, p, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5A17));
        lk_req = 0; lk_vpn = 0; wr_en = 0; wr_use_idx = 0; wr_idx = 0;
        wr_vpn = 0; wr_ppn = 0; flush = 0;
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state at the ports
        check("R1", "rs_valid", 32'(rs_valid), 0);
        check("R1", "trap_req", 32'(trap_req), 0);
        check("R1", "fault_pend", 32'(fault_pend), 0);
        check("R1", "fault_vpn", 32'(fault_vpn), 0);
        check("R1", "rs_ppn", 32'(rs_ppn), 0);
        look("R1", 20'h00005);              // nothing valid: miss
        // R3/R4: first miss captured, second does not overwrite
        look("R3", 20'h00100);
        check("R4", "first fault", 32'(fault_vpn), 32'h00005);
        look("R4", 20'h00200);
        // R5/R2: refill clears pending, then hits
        put("R5", 1'b0, 6'd0, 20'h00100, 20'h00ABC);
        look("R2", 20'h00100);
        check("R2", "hit ppn", 32'(rs_ppn), 32'h00ABC);
        // R9: lookup in same cycle as write sees old contents
        cyc("R9", 1'b1, 20'h00300, 1'b1, 1'b0, 6'd0, 20'h00300, 20'h00333, 1'b0);
        check("R9", "same-cycle miss", 32'(rs_hit), 0);
        look("R9", 20'h00300);
        // R7: duplicate page overwrites its slot, even with explicit index
        put("R7", 1'b1, 6'd40, 20'h00100, 20'h00111);
        look("R7", 20'h00100);
        check("R7", "replaced ppn", 32'(rs_ppn), 32'h00111);
        // R5: explicit slot; second explicit write to same slot evicts
        put("R5", 1'b1, 6'd10, 20'h00400, 20'h00444);
        look("R5", 20'h00400);
        put("R5", 1'b1, 6'd10, 20'h00500, 20'h00555);
        look("R5", 20'h00400);
        check("R5", "evicted by index", 32'(rs_hit), 0);
        look("R5", 20'h00500);
        // R8/R9: flush with same-cycle lookup sees old; afterwards all gone
        cyc("R9", 1'b1, 20'h00500, 1'b0, 1'b0, 6'd0, 20'h0, 20'h0, 1'b1);
        check("R9", "pre-flush hit", 32'(rs_hit), 1);
        look("R8", 20'h00500);
        look("R8", 20'h00100);
        // R8: write under flush dropped
        cyc("R8", 1'b0, 20'h0, 1'b1, 1'b0, 6'd0, 20'h00777, 20'h00077, 1'b1);
        look("R8", 20'h00777);
        check("R8", "dropped write", 32'(rs_hit), 0);
        // R6: 64 fresh round-robin installs, then one more wraps
        cyc("R6", 1'b0, 20'h0, 1'b0, 1'b0, 6'd0, 20'h0, 20'h0, 1'b1);
        for (int i = 0; i < NE; i++)
            put("R6", 1'b0, 6'd0, 20'h10000 + 20'(i), 20'h20000 + 20'(i));
        look("R6", 20'h10000);
        put("R6", 1'b0, 6'd0, 20'h1FFFF, 20'h2FFFF);
        look("R6", 20'h10000);
        look("R6", 20'h10001);
        look("R6", 20'h1FFFF);
        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            cyc("RND", r[0], 20'($urandom_range(0, 79)),
                (r[3:1] < 3'd3), r[4], 6'($urandom_range(0, 63)),
                20'($urandom_range(0, 79)), 20'($urandom),
                (r[12:5] == 8'd0));
        end
        finish_run();
    end
endmodule